// File: doc/BRIEF.md
# Keyed Configuration Port with Logical-Device Banks

This block sits on a byte-wide host I/O bus and guards a small set of configuration registers behind an unlock key. While locked it only listens for key bytes written to I/O address 0x2E. Once the full key has arrived it opens an index/data register pair. The value last written to the index register chooses which register the data register reaches. Some registers are global. Others belong to a logical device chosen by a device-number register.

The block drives the activation bits of two serial-port devices, a clock-source select and a software-suspend flag. A strap input lets two such blocks share one bus: a chip-select bit decides which of them accepts data writes. Writing the exit bit to a write-only control register relocks the interface. After that, the full key is needed again.

Top module: `cfg_port_unlock`

## Requirements
- R1: On a synchronous active-low reset every register bit clears to 0, the interface is locked and all of `uart_en`, `clk24_sel` and `suspend` are 0.
- R2: The writes 0x87, 0x01, 0x55, 0x55, made in that order to address 0x2E, unlock the block at base 0x2E. The index register is then at the base and the data register at base+1. A read of the index address returns the last index written. A read in the same cycle as a data write returns the value held before that write.
- R3: If the fourth key byte is 0xAA instead of 0x55, the block unlocks at base 0x4E. Accesses to 0x2E/0x2F then read 0xFF and have no effect.
- R4: A byte that breaks the key returns the matcher to its start. If that byte is 0x87, it counts as the first key byte.
- R5: While locked, index/data writes have no effect and every read returns 0xFF. A read of any address other than the open index/data pair also returns 0xFF.
- R6: Global index 0x07 holds the device number. Device-specific index 0x30 bit 0 sets the activation bit of the selected device. Device 1 drives `uart_en[0]` and device 2 drives `uart_en[1]`. For any other device number, 0x30 writes change nothing and 0x30 reads give 0x00.
- R7: Global index 0x24 bit 0 drives `clk24_sel` and global index 0x23 bit 0 drives `suspend`. Both read back with bits 7:1 as 0.
- R8: Global index 0x22 bit 7 reads back in bit 7, with bits 6:0 as 0. Until 0x22 is written, data writes are accepted. After that, data writes other than to 0x22 are accepted only while bit 7 equals `strap_sel`. Writes to 0x22 are always accepted.
- R9: An accepted write to index 0x02 with bit 1 set relocks the block and leaves the register values unchanged. With bit 1 clear it has no effect. Index 0x02 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Host I/O write strobe, one cycle per write |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte, valid in the cycle of `io_rd`; 0xFF when nothing answers |
| strap_sel | input | 1 | Board strap compared with chip-select bit 7 |
| uart_en | output | 2 | Serial-port device activation bits |
| clk24_sel | output | 1 | Clock-source select |
| suspend | output | 1 | Software-suspend flag |

## Verification
A host read and a host write can land in the same cycle, and a write can arrive in the same cycle as a change of the strap. For a read paired with a data write, the bench drives both strobes together. It expects the old register value on `io_rdata` and the new value one cycle later. The random phase changes `strap_sel` between accesses, and the bench model judges each write's acceptance using the strap present at that write's clock edge.

// File: rtl/cfgp_pkg.sv
// Shared constants and types for the keyed configuration port.
// Assumes a byte-wide host bus with 16-bit I/O addresses.
package cfgp_pkg;
    localparam logic [7:0]  KEY_B0    = 8'h87;
    localparam logic [7:0]  KEY_B1    = 8'h01;
    localparam logic [7:0]  KEY_B2    = 8'h55;
    localparam logic [7:0]  KEY_LO    = 8'h55;
    localparam logic [7:0]  KEY_HI    = 8'hAA;
    localparam logic [15:0] PORT_LO   = 16'h002E;
    localparam logic [15:0] PORT_HI   = 16'h004E;
    localparam logic [7:0]  IDX_EXIT  = 8'h02;
    localparam logic [7:0]  IDX_DEV   = 8'h07;
    localparam logic [7:0]  IDX_CHIP  = 8'h22;
    localparam logic [7:0]  IDX_SUSP  = 8'h23;
    localparam logic [7:0]  IDX_CLK   = 8'h24;
    localparam logic [7:0]  IDX_ACT   = 8'h30;

    typedef enum logic [1:0] {KS_IDLE, KS_GOT0, KS_GOT1, KS_GOT2} key_state_t;
endpackage

// File: rtl/cfgp_key_match.sv
// Key sequence matcher. Sees only writes to the key port made while locked.
// Pulses hit when the fourth byte completes the key; hit_alt tells which base.
// Assumes key_wr is already gated by the lock state.
module cfgp_key_match
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       hit,
    output logic       hit_alt
);
    key_state_t st, st_nx;
    key_state_t restart;

    // Next state: advance on the expected byte, else restart (0x87 restarts one step in).
    always_comb begin
        restart = (key_byte == KEY_B0) ? KS_GOT0 : KS_IDLE;
        st_nx   = st;
        hit     = 1'b0;
        hit_alt = 1'b0;
        if (key_wr) begin
            case (st)
                KS_IDLE: st_nx = restart;
                KS_GOT0: st_nx = (key_byte == KEY_B1) ? KS_GOT1 : restart;
                KS_GOT1: st_nx = (key_byte == KEY_B2) ? KS_GOT2 : restart;
                KS_GOT2: begin
                    if (key_byte == KEY_LO) begin
                        hit   = 1'b1;
                        st_nx = KS_IDLE;
                    end else if (key_byte == KEY_HI) begin
                        hit     = 1'b1;
                        hit_alt = 1'b1;
                        st_nx   = KS_IDLE;
                    end else begin
                        st_nx = restart;
                    end
                end
                default: st_nx = KS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= KS_IDLE;
        else        st <= st_nx;
    end

    AST_KEY_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_byte == KEY_B0) |=> (st == KS_GOT0)); // R4
    AST_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(st)); // R4
endmodule

// File: rtl/cfgp_dev_bank.sv
// One logical device's register bank: holds its activation bit.
// Assumes act_we is already qualified by index and chip acceptance.
module cfgp_dev_bank #(
    parameter int unsigned DEV_NUM = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_we,
    input  logic [7:0] ldn,
    input  logic       act_bit,
    output logic       active,
    output logic       chosen
);
    // Bank is addressed when the device-number register names it.
    always_comb chosen = (ldn == 8'(DEV_NUM));

    // Activation bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                active <= 1'b0;
        else if (act_we && chosen) active <= act_bit;
    end

    AST_BANK_UNSELECTED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chosen |=> $stable(active)); // R6
endmodule

// File: rtl/cfgp_regs.sv
// Register file behind the data port: global registers, chip-select
// acceptance, exit request and the generated device banks.
// Assumes we is a single-cycle data-port write made while unlocked.
module cfgp_regs
    import cfgp_pkg::*;
#(
    parameter int unsigned NUM_UART      = 2,
    parameter int unsigned UART_LDN_BASE = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [7:0]          idx,
    input  logic [7:0]          wdata,
    input  logic                strap,
    output logic [7:0]          rd_val,
    output logic                exit_req,
    output logic [NUM_UART-1:0] uart_en,
    output logic                clk24_sel,
    output logic                suspend
);
    logic [7:0]          ldn;
    logic                sel_seen, sel_bit;
    logic                accept, wr_ok;
    logic [NUM_UART-1:0] dev_chosen;

    // Chip acceptance: always for the chip-select register, else by strap match.
    always_comb begin
        accept   = (idx == IDX_CHIP) || !sel_seen || (sel_bit == strap);
        wr_ok    = we && accept;
        exit_req = wr_ok && (idx == IDX_EXIT) && wdata[1];
    end

    // Global registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn       <= 8'h00;
            sel_seen  <= 1'b0;
            sel_bit   <= 1'b0;
            suspend   <= 1'b0;
            clk24_sel <= 1'b0;
        end else if (wr_ok) begin
            case (idx)
                IDX_DEV:  ldn <= wdata;
                IDX_CHIP: begin
                    sel_seen <= 1'b1;
                    sel_bit  <= wdata[7];
                end
                IDX_SUSP: suspend   <= wdata[0];
                IDX_CLK:  clk24_sel <= wdata[0];
                default:  ;
            endcase
        end
    end

    // One bank per serial-port device, numbered from UART_LDN_BASE.
    for (genvar g = 0; g < NUM_UART; g++) begin : g_bank
        cfgp_dev_bank #(.DEV_NUM(UART_LDN_BASE + g)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_we  (wr_ok && (idx == IDX_ACT)),
            .ldn     (ldn),
            .act_bit (wdata[0]),
            .active  (uart_en[g]),
            .chosen  (dev_chosen[g])
        );
    end

    // Read mux for the data port.
    always_comb begin
        case (idx)
            IDX_DEV:  rd_val = ldn;
            IDX_CHIP: rd_val = {sel_bit, 7'b0};
            IDX_SUSP: rd_val = {7'b0, suspend};
            IDX_CLK:  rd_val = {7'b0, clk24_sel};
            IDX_ACT:  rd_val = {7'b0, |(dev_chosen & uart_en)};
            default:  rd_val = 8'h00;
        endcase
    end

    AST_FOREIGN_STRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel_seen && sel_bit != strap && idx == IDX_CLK) |=> $stable(clk24_sel)); // R8
    AST_SUSP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel_seen && idx == IDX_SUSP) |=> (suspend == $past(wdata[0]))); // R7
endmodule

// File: rtl/cfg_port_unlock.sv
// Top: keyed configuration port. Routes key writes while locked, then opens
// an index/data pair at the base chosen by the key's last byte.
// Assumes one host access per strobe cycle; io_rdata is combinational.
module cfg_port_unlock
    import cfgp_pkg::*;
#(
    parameter int unsigned NUM_UART      = 2,
    parameter int unsigned UART_LDN_BASE = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [15:0]         io_addr,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    input  logic                strap_sel,
    output logic [NUM_UART-1:0] uart_en,
    output logic                clk24_sel,
    output logic                suspend
);
    logic        unlocked, base_alt;
    logic [7:0]  idx;
    logic [15:0] base;
    logic        at_idx, at_dat, key_wr, key_hit, key_alt, exit_req;
    logic [7:0]  rd_val;

    // Address decode against the current base.
    always_comb begin
        base   = base_alt ? PORT_HI : PORT_LO;
        at_idx = unlocked && (io_addr == base);
        at_dat = unlocked && (io_addr == base + 16'd1);
        key_wr = io_wr && !unlocked && (io_addr == PORT_LO);
    end

    cfgp_key_match i_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (io_wdata),
        .hit      (key_hit),
        .hit_alt  (key_alt)
    );

    // Lock state, base choice and index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            base_alt <= 1'b0;
            idx      <= 8'h00;
        end else begin
            if (key_hit) begin
                unlocked <= 1'b1;
                base_alt <= key_alt;
            end else if (exit_req) begin
                unlocked <= 1'b0;
            end
            if (io_wr && at_idx) idx <= io_wdata;
        end
    end

    cfgp_regs #(.NUM_UART(NUM_UART), .UART_LDN_BASE(UART_LDN_BASE)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (io_wr && at_dat),
        .idx       (idx),
        .wdata     (io_wdata),
        .strap     (strap_sel),
        .rd_val    (rd_val),
        .exit_req  (exit_req),
        .uart_en   (uart_en),
        .clk24_sel (clk24_sel),
        .suspend   (suspend)
    );

    // Read return: index, data, or the idle value.
    always_comb begin
        if (io_rd && at_idx)      io_rdata = idx;
        else if (io_rd && at_dat) io_rdata = rd_val;
        else                      io_rdata = 8'hFF;
    end

    AST_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(io_wr && io_addr == PORT_LO)); // R2
    AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> !unlocked); // R9
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && $past(unlocked)) |-> $stable(base_alt)); // R3
    AST_LOCKED_READS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_rd) |-> (io_rdata == 8'hFF)); // R5
endmodule

// File: tb/test_cfg_port_unlock.sv
module test_cfg_port_unlock;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, io_rd = 1'b0, strap_sel = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic [1:0]  uart_en;
    logic        clk24_sel, suspend;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_unlock i_cfg_port_unlock (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .strap_sel(strap_sel),
        .uart_en(uart_en), .clk24_sel(clk24_sel), .suspend(suspend));

    int vectors = 0, miscompares = 0, cyc = 0;
    bit done = 0;

    // Model state, derived from the requirements.
    int          m_key = 0;
    bit          m_unl = 0, m_selw = 0, m_selb = 0, m_sus = 0, m_clk = 0;
    logic [15:0] m_base = 16'h2E;
    logic [7:0]  m_idx = 0, m_ldn = 0;
    logic [1:0]  m_en = 0;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp, string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_reg(input logic [7:0] i);
        case (i)
            8'h07:   return m_ldn;
            8'h22:   return {m_selb, 7'b0};
            8'h23:   return {7'b0, m_sus};
            8'h24:   return {7'b0, m_clk};
            8'h30:   return (m_ldn == 8'd1) ? {7'b0, m_en[0]} :
                            (m_ldn == 8'd2) ? {7'b0, m_en[1]} : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [15:0] a);
        if (!m_unl)              return 8'hFF;
        if (a == m_base)         return m_idx;
        if (a == m_base + 16'd1) return m_reg(m_idx);
        return 8'hFF;
    endfunction

    function automatic int key_restart(input logic [7:0] d);
        return (d == 8'h87) ? 1 : 0;
    endfunction

    task automatic m_apply(input logic [15:0] a, input logic [7:0] d);
        if (!m_unl) begin
            if (a == 16'h2E) begin
                case (m_key)
                    0: m_key = key_restart(d);
                    1: m_key = (d == 8'h01) ? 2 : key_restart(d);
                    2: m_key = (d == 8'h55) ? 3 : key_restart(d);
                    default: begin
                        if (d == 8'h55)      begin m_unl = 1; m_base = 16'h2E; m_key = 0; end
                        else if (d == 8'hAA) begin m_unl = 1; m_base = 16'h4E; m_key = 0; end
                        else m_key = key_restart(d);
                    end
                endcase
            end
        end else if (a == m_base) begin
            m_idx = d;
        end else if (a == m_base + 16'd1) begin
            if (m_idx == 8'h22 || !m_selw || m_selb == strap_sel) begin
                case (m_idx)
                    8'h02: if (d[1]) begin m_unl = 0; m_key = 0; end
                    8'h07: m_ldn = d;
                    8'h22: begin m_selw = 1; m_selb = d[7]; end
                    8'h23: m_sus = d[0];
                    8'h24: m_clk = d[0];
                    8'h30: begin
                        if (m_ldn == 8'd1) m_en[0] = d[0];
                        else if (m_ldn == 8'd2) m_en[1] = d[0];
                    end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1; io_addr = a; io_wdata = d;
        @(posedge clk);
        m_apply(a, d);
        #1 io_wr = 0;
    endtask

    task automatic do_rd(input logic [15:0] a, input string req);
        @(negedge clk);
        io_rd = 1; io_addr = a;
        #1 chk(req, {8'h0, io_rdata}, {8'h0, m_read(a)}, $sformatf("read %0h", a));
        @(posedge clk);
        #1 io_rd = 0;
    endtask

    task automatic chk_out(input string req);
        chk(req, {14'h0, uart_en}, {14'h0, m_en}, "uart_en");
        chk(req, {15'h0, clk24_sel}, {15'h0, m_clk}, "clk24_sel");
        chk(req, {15'h0, suspend}, {15'h0, m_sus}, "suspend");
    endtask

    task automatic send_key(input logic [7:0] last);
        do_wr(16'h2E, 8'h87); do_wr(16'h2E, 8'h01);
        do_wr(16'h2E, 8'h55); do_wr(16'h2E, last);
    endtask

    task automatic cfg(input logic [7:0] i, input logic [7:0] d);
        do_wr(m_base, i); do_wr(m_base + 16'd1, d);
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            vectors++; miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            report();
        end
    end

    initial begin
        logic [15:0] addrs [5];
        logic [7:0]  idxs  [7];
        logic [7:0]  keyb  [4];
        void'($urandom(32'h5EED_C0F1));
        addrs = '{16'h2E, 16'h2F, 16'h4E, 16'h4F, 16'h60};
        idxs  = '{8'h02, 8'h07, 8'h22, 8'h23, 8'h24, 8'h30, 8'h41};
        keyb  = '{8'h87, 8'h01, 8'h55, 8'hAA};

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state
        chk_out("R1");
        do_rd(16'h2E, "R1"); do_rd(16'h2F, "R1");

        // R5: locked writes ignored, reads idle
        do_wr(16'h2E, 8'h24); do_wr(16'h2F, 8'h01);
        chk_out("R5"); do_rd(16'h2F, "R5");

        // R2: key unlocks at 0x2E
        send_key(8'h55);
        do_rd(16'h2E, "R2");
        cfg(8'h24, 8'h01); chk_out("R2"); do_rd(16'h2F, "R2");
        do_rd(16'h60, "R5");

        // R6: device banks
        cfg(8'h07, 8'h01); cfg(8'h30, 8'h01); chk_out("R6");
        cfg(8'h07, 8'h02); cfg(8'h30, 8'h01); chk_out("R6"); do_rd(16'h2F, "R6");
        cfg(8'h07, 8'h05); cfg(8'h30, 8'h00); chk_out("R6"); do_rd(16'h2F, "R6");
        cfg(8'h07, 8'h01); cfg(8'h30, 8'h00); chk_out("R6");

        // R7: suspend and clock select read back
        cfg(8'h23, 8'hFF); chk_out("R7"); do_rd(16'h2F, "R7");

        // R2: read and write of the data register in the same cycle
        @(negedge clk);
        io_wr = 1; io_rd = 1; io_addr = 16'h2F; io_wdata = 8'h00;
        #1 chk("R2", {8'h0, io_rdata}, 16'h0001, "same-cycle read old value");
        @(posedge clk); m_apply(16'h2F, 8'h00);
        #1 begin io_wr = 0; io_rd = 0; end
        chk_out("R2"); do_rd(16'h2F, "R2");

        // R9: exit register
        cfg(8'h02, 8'hFD); do_rd(16'h2F, "R9"); do_rd(16'h2E, "R9");
        cfg(8'h02, 8'h02); do_rd(16'h2E, "R9"); chk_out("R9");

        // R4: repeated 0x87 counts as the first byte
        do_wr(16'h2E, 8'h87); send_key(8'h55); do_rd(16'h2E, "R4");
        cfg(8'h02, 8'h02);
        do_wr(16'h2E, 8'h87); do_wr(16'h2E, 8'h01); do_wr(16'h2E, 8'h33);
        do_wr(16'h2E, 8'h55); do_wr(16'h2E, 8'h55); do_rd(16'h2E, "R4");
        do_wr(16'h2E, 8'h87); do_wr(16'h2E, 8'h01); do_wr(16'h2E, 8'h55);
        send_key(8'h55); do_rd(16'h2E, "R4");
        cfg(8'h02, 8'h02);

        // R3: alternate base
        send_key(8'hAA);
        do_rd(16'h4E, "R3"); do_rd(16'h2E, "R3");
        do_wr(16'h2E, 8'h24); do_wr(16'h2F, 8'h01); chk_out("R3");
        cfg(8'h24, 8'h01); chk_out("R3");

        // R8: chip select against strap
        cfg(8'h22, 8'h80); do_rd(16'h4F, "R8");
        cfg(8'h24, 8'h00); chk_out("R8");
        strap_sel = 1; cfg(8'h24, 8'h00); chk_out("R8");
        strap_sel = 0; cfg(8'h22, 8'h00); cfg(8'h23, 8'h01); chk_out("R8");

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [15:0] a;
            logic [7:0]  d;
            r = $urandom % 100;
            if (r < 3) strap_sel = ~strap_sel;
            if (n % 60 == 0 && !m_unl) send_key(($urandom % 2) ? 8'hAA : 8'h55);
            a = addrs[$urandom % 5];
            if (a == 16'h2E && !m_unl)  d = keyb[$urandom % 4];
            else if (a == m_base)       d = idxs[$urandom % 7];
            else if ($urandom % 8 == 0) d = 8'h02;
            else                        d = 8'($urandom);
            if (r < 60) begin
                do_wr(a, d);
                chk_out("R6");
            end else begin
                do_rd(a, "R5");
            end
        end
        report();
    end
endmodule